// File: doc/BRIEF.md
# HI/LO multiply-divide unit with read interlock

This block holds the HI and LO result registers of a 32-bit processor core and produces them for signed and unsigned multiply and divide. The core presents one request per cycle: an arithmetic operation with two operands, a direct write of HI or LO, or a read of HI or LO. An arithmetic operation is accepted in a single cycle. A down-counter then models how long the result takes to become available. The multiply time depends on the magnitude of the first operand. A divide always takes the same fixed time.

A read of HI or LO that arrives while the counter still shows more than one remaining cycle raises `stall`. The core holds the read request steady until `stall` drops, and in that cycle the data is returned. When exactly one cycle remains, that last cycle is absorbed: the read completes at once and the counter is cleared. Divide by zero and the single signed overflow case give fixed, defined results. They do not trap.

Top module: `muldiv_unit`

## Requirements
- R1: After reset HI and LO are zero and the unit is idle. A read of either register returns 0 with no stall.
- R2: The `req_op` encoding is as follows: 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide, 4 = write HI from `src_a`, 5 = write LO from `src_a`, 6 = read HI, 7 = read LO. A multiply forms the 64-bit product. Its bits 31:0 go to LO and bits 63:32 go to HI.
- R3: A signed divide with a nonzero divisor writes the quotient, truncated toward zero, to LO. It writes the remainder, which carries the sign of the dividend, to HI. An unsigned divide writes the unsigned quotient to LO and the unsigned remainder to HI.
- R4: A divide by zero sets HI to the dividend. For an unsigned divide, LO becomes 0xFFFFFFFF. For a signed divide, LO becomes 1 if the dividend is negative and 0xFFFFFFFF otherwise.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: The latency L of an operation is 37 for both divides. Suppose an arithmetic operation is accepted in cycle c and a read is presented in cycle c+k, where k ≥ 1. The read then stalls for max(0, L−k−1) cycles and returns its data in the first cycle without a stall.
- R7: The multiply latency comes from the leading-zero count z of (x OR 0x400). For an unsigned multiply, x is `src_a`. For a signed multiply, x is `src_a` XOR its sign replicated to all bits. L is 6 when z ≥ 21, 9 when 12 ≤ z ≤ 20, and 13 otherwise.
- R8: A read presented when exactly one cycle of latency remains (k = L−1) does not stall. It returns the new result, and a read in the next cycle does not stall either.
- R9: A write of HI or LO takes effect at the end of its cycle with no stall. A read in the following cycle returns the written value.
- R10: An arithmetic operation accepted while an earlier one is still counting restarts the latency from the new operation and replaces both HI and LO.
- R11: `stall` is high only in a cycle that carries a read request. `rd_valid` is high exactly in a read cycle without a stall, and `stall` and `rd_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request code, see R2 |
| src_a | input | 32 | First operand, dividend, or value to write |
| src_b | input | 32 | Second operand or divisor |
| stall | output | 1 | Read must be held and retried next cycle |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | HI or LO value for a granted read |

## Verification
Two functions can fall in the same cycle: the counter's final countdown, and a read that arrives exactly when one cycle remains. The bench issues each operation and then presents the read at a swept distance k. That distance covers k = L−1 (absorbed, zero stall), k = L−2 (one stall), and distances past the end of the latency. The observed stall count is compared with max(0, L−k−1), where L is computed in the bench from the operand's leading zeros. A second case restarts the counter by issuing a short multiply directly after a divide. The stall is then judged against the multiply's latency, and the returned data against the multiply's product.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        MD_MUL_S   = 3'd0,
        MD_MUL_U   = 3'd1,
        MD_DIV_S   = 3'd2,
        MD_DIV_U   = 3'd3,
        MD_SET_HI  = 3'd4,
        MD_SET_LO  = 3'd5,
        MD_GET_HI  = 3'd6,
        MD_GET_LO  = 3'd7
    } md_op_e;

    function automatic logic md_is_arith(input md_op_e op);
        return (op == MD_MUL_S) || (op == MD_MUL_U) ||
               (op == MD_DIV_S) || (op == MD_DIV_U);
    endfunction

    function automatic logic md_is_read(input md_op_e op);
        return (op == MD_GET_HI) || (op == MD_GET_LO);
    endfunction

endpackage

// File: rtl/muldiv_lzc.sv
module muldiv_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] zeros
);
    logic found;

    always_comb begin
        zeros = CW'(W);
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                zeros = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/muldiv_latency.sv
module muldiv_latency
    import muldiv_pkg::*;
#(
    parameter int W         = 32,
    parameter int CNT_W     = 6,
    parameter int FLOOR_BIT = 10,
    parameter int LZ_FAST   = 21,
    parameter int LZ_MID    = 12,
    parameter int LAT_FAST  = 6,
    parameter int LAT_MID   = 9,
    parameter int LAT_SLOW  = 13,
    parameter int LAT_DIV   = 37
) (
    input  md_op_e           op,
    input  logic [W-1:0]     opnd,
    output logic [CNT_W-1:0] cycles
);
    localparam int CW = $clog2(W + 1);
    localparam logic [W-1:0] FLOOR_MASK = W'(1) << FLOOR_BIT;

    logic [W-1:0]  mag;
    logic [CW-1:0] lz;

    always_comb begin
        if (op == MD_MUL_S) begin
            mag = opnd ^ {W{opnd[W-1]}};
        end else begin
            mag = opnd;
        end
        mag = mag | FLOOR_MASK;
    end

    muldiv_lzc #(.W(W), .CW(CW)) u_lzc (
        .vec   (mag),
        .zeros (lz)
    );

    always_comb begin
        if ((op == MD_DIV_S) || (op == MD_DIV_U)) begin
            cycles = CNT_W'(LAT_DIV);
        end else if (lz >= CW'(LZ_FAST)) begin
            cycles = CNT_W'(LAT_FAST);
        end else if (lz >= CW'(LZ_MID)) begin
            cycles = CNT_W'(LAT_MID);
        end else begin
            cycles = CNT_W'(LAT_SLOW);
        end
    end
endmodule

// File: rtl/muldiv_arith.sv
module muldiv_arith
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] hi_res,
    output logic [W-1:0] lo_res
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [PW-1:0]       prod_s;
    logic [PW-1:0]       prod_u;
    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;
    logic signed [W-1:0] sq;
    logic signed [W-1:0] sr;
    logic [W-1:0]        uq;
    logic [W-1:0]        ur;
    logic                b_zero;
    logic                s_ovf;

    always_comb begin
        prod_s = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
        prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        b_zero = (b == '0);
        s_ovf  = (a == MOST_NEG) && (b == ALL_ONES);
        sa     = $signed(a);
        sb     = b_zero ? $signed(W'(1)) : $signed(b);
        sq     = s_ovf ? $signed(MOST_NEG) : sa / sb;
        sr     = s_ovf ? $signed(W'(0)) : sa % sb;
        uq     = a / (b_zero ? W'(1) : b);
        ur     = a % (b_zero ? W'(1) : b);

        hi_res = '0;
        lo_res = '0;
        case (op)
            MD_MUL_S: begin
                lo_res = prod_s[W-1:0];
                hi_res = prod_s[PW-1:W];
            end
            MD_MUL_U: begin
                lo_res = prod_u[W-1:0];
                hi_res = prod_u[PW-1:W];
            end
            MD_DIV_S: begin
                if (b_zero) begin
                    lo_res = a[W-1] ? W'(1) : ALL_ONES;
                    hi_res = a;
                end else begin
                    lo_res = sq;
                    hi_res = sr;
                end
            end
            MD_DIV_U: begin
                if (b_zero) begin
                    lo_res = ALL_ONES;
                    hi_res = a;
                end else begin
                    lo_res = uq;
                    hi_res = ur;
                end
            end
            default: begin
                lo_res = '0;
                hi_res = '0;
            end
        endcase
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W         = 32,
    parameter int FLOOR_BIT = 10,
    parameter int LZ_FAST   = 21,
    parameter int LZ_MID    = 12,
    parameter int LAT_FAST  = 6,
    parameter int LAT_MID   = 9,
    parameter int LAT_SLOW  = 13,
    parameter int LAT_DIV   = 37
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [2:0]   req_op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         stall,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam int LAT_MAX = (LAT_DIV > LAT_SLOW) ? LAT_DIV : LAT_SLOW;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [W-1:0]     hi;
        logic [W-1:0]     lo;
        logic [CNT_W-1:0] left;
    } md_state_t;

    md_state_t        st_d, st_q;
    md_op_e           op;
    logic             go_arith;
    logic             go_read;
    logic [W-1:0]     res_hi;
    logic [W-1:0]     res_lo;
    logic [CNT_W-1:0] lat;
    logic [W-1:0]     hi_q;
    logic [W-1:0]     lo_q;

    assign op   = md_op_e'(req_op);
    assign hi_q = st_q.hi;
    assign lo_q = st_q.lo;

    muldiv_arith #(.W(W)) u_arith (
        .op     (op),
        .a      (src_a),
        .b      (src_b),
        .hi_res (res_hi),
        .lo_res (res_lo)
    );

    muldiv_latency #(
        .W         (W),
        .CNT_W     (CNT_W),
        .FLOOR_BIT (FLOOR_BIT),
        .LZ_FAST   (LZ_FAST),
        .LZ_MID    (LZ_MID),
        .LAT_FAST  (LAT_FAST),
        .LAT_MID   (LAT_MID),
        .LAT_SLOW  (LAT_SLOW),
        .LAT_DIV   (LAT_DIV)
    ) u_lat (
        .op     (op),
        .opnd   (src_a),
        .cycles (lat)
    );

    always_comb begin
        go_arith = req_valid && md_is_arith(op);
        go_read  = req_valid && md_is_read(op);
        stall    = go_read && (st_q.left > CNT_ONE);
        rd_valid = go_read && !stall;
        rd_data  = (op == MD_GET_HI) ? st_q.hi : st_q.lo;

        st_d = st_q;
        if (st_q.left != '0) begin
            st_d.left = st_q.left - CNT_ONE;
        end
        if (go_arith) begin
            st_d.hi   = res_hi;
            st_d.lo   = res_lo;
            st_d.left = lat - CNT_ONE;
        end
        if (req_valid && (op == MD_SET_HI)) begin
            st_d.hi = src_a;
        end
        if (req_valid && (op == MD_SET_LO)) begin
            st_d.lo = src_a;
        end
        if (rd_valid) begin
            st_d.left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [2:0]   req_op,
    input logic [W-1:0] src_a,
    input logic [W-1:0] src_b,
    input logic         stall,
    input logic         rd_valid,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    logic is_read;
    assign is_read = req_valid && (req_op[2:1] == 2'b11);

    assert_stall_only_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> is_read);

    assert_grant_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (is_read && !stall));

    assert_div_blocks_next_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2) |=> (!is_read || stall));

    assert_stall_release_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall) && !stall && is_read) |-> rd_valid);

    assert_write_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |=> (hi_q == $past(src_a)));

    assert_udiv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd3 && src_b == '0) |=>
            (lo_q == {W{1'b1}} && hi_q == $past(src_a)));
endmodule

bind muldiv_unit muldiv_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .src_a     (src_a),
    .src_b     (src_b),
    .stall     (stall),
    .rd_valid  (rd_valid),
    .hi_q      (hi_q),
    .lo_q      (lo_q)
);

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam logic [2:0] OP_MULS = 3'd0, OP_MULU = 3'd1, OP_DIVS = 3'd2,
                           OP_DIVU = 3'd3, OP_SETHI = 3'd4, OP_SETLO = 3'd5,
                           OP_GETHI = 3'd6, OP_GETLO = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        stall;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    muldiv_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .src_a(src_a), .src_b(src_b), .stall(stall), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [2:0] op, input logic [31:0] a);
        logic [31:0] x;
        int z;
        if (op == OP_DIVS || op == OP_DIVU) return 37;
        x = (op == OP_MULS) ? (a ^ {32{a[31]}}) : a;
        x = x | 32'h400;
        z = 0;
        for (int i = 31; i >= 0; i--) begin
            if (x[i]) break;
            z++;
        end
        if (z >= 21) return 6;
        if (z >= 12) return 9;
        return 13;
    endfunction

    task automatic exp_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] hi, output logic [31:0] lo);
        longint sp;
        longint unsigned up;
        int sa, sb;
        sa = int'(a);
        sb = int'(b);
        hi = 0; lo = 0;
        case (op)
            OP_MULS: begin sp = longint'(sa) * longint'(sb); lo = sp[31:0]; hi = sp[63:32]; end
            OP_MULU: begin up = {32'd0, a} * {32'd0, b}; lo = up[31:0]; hi = up[63:32]; end
            OP_DIVS: begin
                if (b == 0) begin lo = a[31] ? 32'd1 : 32'hFFFFFFFF; hi = a; end
                else if (a == 32'h80000000 && b == 32'hFFFFFFFF) begin lo = 32'h80000000; hi = 0; end
                else begin lo = 32'(sa / sb); hi = 32'(sa % sb); end
            end
            default: begin
                if (b == 0) begin lo = 32'hFFFFFFFF; hi = a; end
                else begin lo = a / b; hi = a % b; end
            end
        endcase
    endtask

    // Present a request for one cycle; checks no stall/grant for non-read (R11).
    task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        req_valid = 1'b1; req_op = op; src_a = a; src_b = b;
        @(negedge clk);
        check(!stall && !rd_valid, "R11 no stall/grant on non-read", {30'd0, stall, rd_valid}, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Hold a read until granted; returns data and stall count.
    task automatic read_reg(input logic [2:0] op, output logic [31:0] data, output int stalls);
        stalls = 0;
        req_valid = 1'b1; req_op = op;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (stall) begin
                stalls++;
                check(!rd_valid, "R11 grant during stall", {31'd0, rd_valid}, 0);
                @(posedge clk); #1;
            end else begin
                check(rd_valid, "R11 grant when not stalled", {31'd0, rd_valid}, 1);
                data = rd_data;
                @(posedge clk); #1;
                break;
            end
        end
        req_valid = 1'b0;
    endtask

    task automatic run_case(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                            input int k);
        logic [31:0] eh, el, got;
        int L, s, es;
        string tag;
        L = exp_lat(op, a);
        exp_res(op, a, b, eh, el);
        if (op == OP_MULS || op == OP_MULU) tag = "R2";
        else if (b == 0) tag = "R4";
        else if (op == OP_DIVS && a == 32'h80000000 && b == 32'hFFFFFFFF) tag = "R5";
        else tag = "R3";
        send(op, a, b);
        repeat (k - 1) begin @(posedge clk); #1; end
        read_reg(OP_GETLO, got, s);
        es = (L - k - 1 > 0) ? L - k - 1 : 0;
        check(s == es, (k == L - 1) ? "R8 absorbed stall" :
              ((op >= OP_DIVS) ? "R6 stall count" : "R7 stall count"), s, es);
        check(got == el, {tag, " LO"}, got, el);
        read_reg(OP_GETHI, got, s);
        check(s == 0, "R8 second read stall", s, 0);
        check(got == eh, {tag, " HI"}, got, eh);
    endtask

    logic [31:0] vals [12] = '{32'h0, 32'h1, 32'h5, 32'h7FF, 32'h800, 32'hFFFFF,
                              32'h100000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF,
                              32'hFFFFF800, 32'h12345678};

    initial begin
        logic [31:0] got;
        int s;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!stall && !rd_valid, "R11 idle after reset", {30'd0, stall, rd_valid}, 0);
        @(posedge clk); #1;
        // R1 reset state
        read_reg(OP_GETHI, got, s);
        check(got == 0 && s == 0, "R1 HI after reset", got, 0);
        read_reg(OP_GETLO, got, s);
        check(got == 0 && s == 0, "R1 LO after reset", got, 0);

        // R9 direct writes
        send(OP_SETLO, 32'hCAFE0001, 32'h0);
        read_reg(OP_GETLO, got, s);
        check(s == 0, "R9 write LO no stall", s, 0);
        check(got == 32'hCAFE0001, "R9 write LO value", got, 32'hCAFE0001);
        send(OP_SETHI, 32'h0BAD0002, 32'h0);
        read_reg(OP_GETHI, got, s);
        check(got == 32'h0BAD0002 && s == 0, "R9 write HI value", got, 32'h0BAD0002);

        // R8 / R6 boundaries on divide and multiply
        run_case(OP_DIVS, 32'd100, 32'd7, 36);
        run_case(OP_DIVU, 32'd100, 32'd7, 35);
        run_case(OP_MULU, 32'd3, 32'd4, 5);
        run_case(OP_MULS, 32'hFFFFFFFF, 32'd4, 4);
        run_case(OP_MULU, 32'h00100000, 32'd9, 1);
        run_case(OP_MULU, 32'h80000000, 32'd2, 1);

        // R10 restart: divide then short multiply in the next cycle
        send(OP_DIVU, 32'd1000, 32'd3);
        send(OP_MULU, 32'd6, 32'd7);
        read_reg(OP_GETLO, got, s);
        check(s == 4, "R10 restart stall", s, 4);
        check(got == 32'd42, "R10 restart LO", got, 42);
        read_reg(OP_GETHI, got, s);
        check(got == 32'd0, "R10 restart HI", got, 0);

        // Near-exhaustive sweep of operand pairs over all four arithmetic ops
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                for (int o = 0; o < 4; o++) begin
                    logic [2:0] op;
                    int L, k;
                    op = 3'(o);
                    L = exp_lat(op, vals[i]);
                    k = 1 + ((i * 7 + j * 3 + o) % (L + 1));
                    run_case(op, vals[i], vals[j], k);
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule